// File: doc/BRIEF.md
# Six-Phase 8-Bit Register CPU

This block is a small programmable 8-bit processor with a 16-entry register file and no accumulator. Every instruction is two bytes long and is read from one 256-byte space that holds both code and data. A single synchronous memory port carries instruction fetches, data loads and data stores.

The instruction set has seven operations:

- load a register from a direct address, or with an immediate value;
- store a register to a direct address, or store one register to the address held in another;
- add or subtract two registers;
- a relative jump taken only when a chosen register is zero.

A phase sequencer walks each instruction through six one-cycle steps:

1. fetch of the first byte;
2. fetch of the second byte;
3. decode;
4. operand fetch;
5. execute;
6. result store.

A step that an instruction has no use for still takes its cycle. Debug outputs expose the program counter, the instruction register and the whole register file. The memory itself sits outside the block.

Top module: `byte_cpu`

## Requirements
- R1: While `rst_n` is low and right after it rises, the PC is 0, the IR is 0, all sixteen registers are 0 and `mem_we` is low.
- R2: An instruction takes six cycles, counted from its first-byte phase, where `mem_addr` equals the PC. The memory returns `mem_rdata` one cycle after an address. The first byte enters IR[15:8] at the 2nd clock edge. The second byte enters IR[7:0] and the PC grows by 2 (mod 256) at the 3rd edge. A register result appears at the 5th edge.
- R3: First byte: opcode in bits 7:4, register Rn in bits 3:0. The second byte is the argument: a direct address, an immediate, or a signed offset. For two-register operations, Rm is in bits 7:4 of the argument.
- R4: Opcode 0x0 loads Rn from memory at the argument address. Opcode 0x3 loads the argument into Rn.
- R5: Opcode 0x1 writes Rn to the argument address. Opcode 0x2 writes Rm to the address held in Rn. `mem_we` is high for exactly one cycle, the sixth, and only for these two opcodes.
- R6: Opcode 0x4 sets Rn to Rn+Rm and opcode 0x5 sets Rn to Rn-Rm, both modulo 256, including the case Rn = Rm.
- R7: Opcode 0x6 adds the two's-complement argument to the already advanced PC, modulo 256, when Rn is zero. Otherwise execution continues at PC+2.
- R8: Opcodes 0x7 to 0xF change no register and write no memory. They only advance the PC by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release starts execution at address 0 |
| mem_addr | output | 8 | Memory address for the current phase |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Store strobe, sampled by memory at the rising edge |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| dbg_pc | output | 8 | Program counter |
| dbg_ir | output | 16 | Instruction register, first byte in the upper half |
| dbg_regs | output | 128 | Register file, register i at bits 8i+7:8i |

## Verification
The block has no parameters, so the bench builds it in its only shape: an 8-bit datapath, sixteen registers and a 256-byte space. Because addresses, offsets and register indices all fit in 8 bits, directed programs can reach every corner:

- jumps that wrap below address 0;
- sums that overflow;
- subtractions that go negative;
- register-indirect stores to any byte.

A step-by-step run of one instruction pins the edge at which each phase takes effect. A summation loop of ten iterations checks the whole sequence end to end.

// File: rtl/byte_cpu.sv
module byte_cpu (
  input  logic         clk,
  input  logic         rst_n,
  output logic [7:0]   mem_addr,
  output logic [7:0]   mem_wdata,
  output logic         mem_we,
  input  logic [7:0]   mem_rdata,
  output logic [7:0]   dbg_pc,
  output logic [15:0]  dbg_ir,
  output logic [127:0] dbg_regs
);
  localparam logic [3:0] OP_LDD = 4'h0;
  localparam logic [3:0] OP_STD = 4'h1;
  localparam logic [3:0] OP_STI = 4'h2;
  localparam logic [3:0] OP_LDI = 4'h3;
  localparam logic [3:0] OP_ADD = 4'h4;
  localparam logic [3:0] OP_SUB = 4'h5;
  localparam logic [3:0] OP_JZ  = 4'h6;

  typedef enum logic [2:0] {PH_F0, PH_F1, PH_DEC, PH_OPF, PH_EXE, PH_STR} phase_t;

  phase_t      phase;
  logic [7:0]  pc;
  logic [15:0] ir;
  logic [7:0]  rf [16];

  logic [3:0] op, rn, rm;
  logic [7:0] arg, rn_val, rm_val;

  assign op     = ir[15:12];
  assign rn     = ir[11:8];
  assign rm     = ir[7:4];
  assign arg    = ir[7:0];
  assign rn_val = rf[rn];
  assign rm_val = rf[rm];

  always_comb begin
    case (phase)
      PH_F1:   mem_addr = pc + 8'd1;
      PH_OPF:  mem_addr = arg;
      PH_STR:  mem_addr = (op == OP_STI) ? rn_val : arg;
      default: mem_addr = pc;
    endcase
  end

  assign mem_we    = (phase == PH_STR) && (op == OP_STD || op == OP_STI);
  assign mem_wdata = (op == OP_STI) ? rm_val : rn_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_F0;
      pc    <= 8'd0;
      ir    <= 16'd0;
      for (int i = 0; i < 16; i++) rf[i] <= 8'd0;
    end else begin
      case (phase)
        PH_F0:  phase <= PH_F1;
        PH_F1: begin
          ir[15:8] <= mem_rdata;
          phase    <= PH_DEC;
        end
        PH_DEC: begin
          ir[7:0] <= mem_rdata;
          pc      <= pc + 8'd2;
          phase   <= PH_OPF;
        end
        PH_OPF: phase <= PH_EXE;
        PH_EXE: begin
          case (op)
            OP_LDD: rf[rn] <= mem_rdata;
            OP_LDI: rf[rn] <= arg;
            OP_ADD: rf[rn] <= rn_val + rm_val;
            OP_SUB: rf[rn] <= rn_val - rm_val;
            OP_JZ:  if (rn_val == 8'd0) pc <= pc + arg;
            default: ;
          endcase
          phase <= PH_STR;
        end
        default: phase <= PH_F0;
      endcase
    end
  end

  assign dbg_pc = pc;
  assign dbg_ir = ir;

  for (genvar g = 0; g < 16; g++) begin : g_dbg
    assign dbg_regs[g*8 +: 8] = rf[g];
  end
endmodule

module byte_cpu_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   phase,
  input logic [15:0]  ir,
  input logic [7:0]   pc,
  input logic         mem_we,
  input logic [127:0] dbg_regs
);
  p_we_store_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ir[15:12] == 4'h1 || ir[15:12] == 4'h2));

  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd5) |=> (phase == 3'd0));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd5) |=> (phase == $past(phase) + 3'd1));

  p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd1 && phase != 3'd2) |=> $stable(ir));

  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd2 && !(phase == 3'd4 && ir[15:12] == 4'h6)) |=> $stable(pc));

  p_nop_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && ir[15:12] >= 4'h6) |=> $stable(dbg_regs));
endmodule

bind byte_cpu byte_cpu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .phase(phase), .ir(ir), .pc(pc),
  .mem_we(mem_we), .dbg_regs(dbg_regs)
);

// File: tb/byte_cpu_tb_top.sv
`timescale 1ns/1ps
module byte_cpu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]   mem_addr, mem_wdata, mem_rdata;
  logic         mem_we;
  logic [7:0]   dbg_pc;
  logic [15:0]  dbg_ir;
  logic [127:0] dbg_regs;

  logic [7:0] mem [256];
  int wr_count;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  byte_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir),
    .dbg_regs(dbg_regs)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [7:0] rg(input int i);
    return dbg_regs[i*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input int a, input logic [7:0] b0, input logic [7:0] b1);
    mem[a] = b0;
    mem[(a + 1) % 256] = b1;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wr_count = 0;
    step(2);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    hold_reset();
    put(0, 8'h31, 8'h42);
    chk("R1 pc", {8'h0, dbg_pc}, 16'h0);
    chk("R1 ir", dbg_ir, 16'h0);
    for (int i = 0; i < 16; i++) chk("R1 reg", {8'h0, rg(i)}, 16'h0);
    chk("R1 we", {15'h0, mem_we}, 16'h0);
    release_reset();
    chk("R1 pc after release", {8'h0, dbg_pc}, 16'h0);
  endtask

  task automatic t_timing();
    hold_reset();
    put(0, 8'h31, 8'h42);
    put(2, 8'h63, 8'hFE);
    release_reset();
    chk("R2 first addr", {8'h0, mem_addr}, 16'h0);
    step(2);
    chk("R2 ir hi at edge 2", dbg_ir, 16'h3100);
    chk("R2 pc at edge 2", {8'h0, dbg_pc}, 16'h0);
    step(1);
    chk("R3 ir full at edge 3", dbg_ir, 16'h3142);
    chk("R2 pc+2 at edge 3", {8'h0, dbg_pc}, 16'h2);
    step(1);
    chk("R2 reg not yet at edge 4", {8'h0, rg(1)}, 16'h0);
    step(1);
    chk("R4 immediate at edge 5", {8'h0, rg(1)}, 16'h42);
    chk("R5 no write for load", {15'h0, mem_we}, 16'h0);
    step(1);
    chk("R2 next fetch addr", {8'h0, mem_addr}, 16'h2);
  endtask

  task automatic t_sum();
    hold_reset();
    put(0,  8'h30, 8'h00);
    put(2,  8'h31, 8'h0A);
    put(4,  8'h32, 8'h01);
    put(6,  8'h33, 8'h00);
    put(8,  8'h61, 8'h06);
    put(10, 8'h40, 8'h10);
    put(12, 8'h51, 8'h20);
    put(14, 8'h63, 8'hF8);
    put(16, 8'h10, 8'h80);
    put(18, 8'h63, 8'hFE);
    release_reset();
    step(400);
    chk("R6 loop sum", {8'h0, rg(0)}, 16'd55);
    chk("R7 loop counter", {8'h0, rg(1)}, 16'd0);
    chk("R5 direct store", {8'h0, mem[8'h80]}, 16'd55);
    chk("R5 one write", wr_count[15:0], 16'd1);
  endtask

  task automatic t_mem();
    hold_reset();
    mem[8'h90] = 8'h5A;
    put(0, 8'h04, 8'h90);
    put(2, 8'h35, 8'hA0);
    put(4, 8'h25, 8'h40);
    put(6, 8'h14, 8'h91);
    put(8, 8'h63, 8'hFE);
    release_reset();
    step(120);
    chk("R4 direct load", {8'h0, rg(4)}, 16'h5A);
    chk("R5 indirect store", {8'h0, mem[8'hA0]}, 16'h5A);
    chk("R5 direct store", {8'h0, mem[8'h91]}, 16'h5A);
    chk("R5 write count", wr_count[15:0], 16'd2);
  endtask

  task automatic t_alu();
    hold_reset();
    put(0,  8'h36, 8'h03);
    put(2,  8'h37, 8'h05);
    put(4,  8'h56, 8'h70);
    put(6,  8'h38, 8'hF0);
    put(8,  8'h39, 8'h20);
    put(10, 8'h48, 8'h90);
    put(12, 8'h3A, 8'h81);
    put(14, 8'h4A, 8'hA0);
    put(16, 8'h6B, 8'hFE);
    release_reset();
    step(150);
    chk("R6 sub negative", {8'h0, rg(6)}, 16'hFE);
    chk("R6 rm untouched", {8'h0, rg(7)}, 16'h05);
    chk("R6 add wrap", {8'h0, rg(8)}, 16'h10);
    chk("R6 add self", {8'h0, rg(10)}, 16'h02);
  endtask

  task automatic t_jump();
    hold_reset();
    put(0,  8'h31, 8'h01);
    put(2,  8'h61, 8'h04);
    put(4,  8'h32, 8'h11);
    put(6,  8'h60, 8'h02);
    put(8,  8'h33, 8'h22);
    put(10, 8'h34, 8'h33);
    put(12, 8'h60, 8'hFE);
    release_reset();
    step(12);
    chk("R7 not taken pc", {8'h0, dbg_pc}, 16'h4);
    step(12);
    chk("R7 taken pc", {8'h0, dbg_pc}, 16'hA);
    step(60);
    chk("R7 fallthrough ran", {8'h0, rg(2)}, 16'h11);
    chk("R7 skipped", {8'h0, rg(3)}, 16'h00);
    chk("R7 target ran", {8'h0, rg(4)}, 16'h33);
  endtask

  task automatic t_nop_wrap();
    hold_reset();
    put(0,     8'h63, 8'hF0);
    put(8'hF2, 8'h7F, 8'hFF);
    put(8'hF4, 8'hC5, 8'h12);
    put(8'hF6, 8'h31, 8'h77);
    put(8'hF8, 8'h63, 8'hFE);
    release_reset();
    step(6);
    chk("R7 backward wrap pc", {8'h0, dbg_pc}, 16'hF2);
    step(12);
    chk("R8 nop pc advance", {8'h0, dbg_pc}, 16'hF6);
    for (int i = 0; i < 16; i++) chk("R8 nop regs", {8'h0, rg(i)}, 16'h0);
    chk("R8 nop no write", wr_count[15:0], 16'd0);
    step(40);
    chk("R8 after nops", {8'h0, rg(1)}, 16'h77);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_timing();
    t_sum();
    t_mem();
    t_alu();
    t_jump();
    t_nop_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule